// File: doc/BRIEF.md
# Edge-to-edge period timer with timeout

This block measures the time between successive rising edges of an incremental-encoder track A. Time is counted in ticks of a local 100 ns timebase, supplied as a one-clock enable pulse on the system clock. The block keeps no link to any external clock-synchronisation scheme. It has no gate input, so it keeps measuring while a neighbouring counter is blocked. Because of that, a period is still available when a frequency measurement cannot be made.

Track A and the tick enable are both sampled through the same fixed-length synchroniser pipeline. A tick and an edge that arrive in the same clock at the pins therefore stay in the same clock inside the block. Each completed interval is registered on the period output together with a one-clock strobe. The interval count saturates instead of wrapping. If the track stays quiet for the timeout span, which is about 1.6 s at the default setting, the reported period is withdrawn: the output is forced to zero and the valid flag drops. The next edge after that only starts a new measurement.

Top module: `edge_period_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, `period_ticks` is 0, `period_stb` is 0 and `period_vld` is 0.
- R2: A cycle whose sampled `trk_a` is 1 after a sampled 0 is a detected edge. The reported period is the number of cycles with `tick_en` high, counted from one detected edge's cycle (inclusive) to the next detected edge's cycle (exclusive), both sampled at the pins.
- R3: Each new period value raises `period_stb` for exactly one clock. In that clock `period_vld` is 1 and `period_ticks` already holds the new value.
- R4: The first detected edge after reset or after a timeout produces no strobe. It only starts timing.
- R5: A period longer than 2^CNT_W-1 ticks is reported as 2^CNT_W-1, all ones.
- R6: When TIMEOUT_TICKS ticks have been counted since the last detected edge with no new edge, `period_ticks` becomes 0 and `period_vld` becomes 0. An interval of TIMEOUT_TICKS-1 ticks is still reported as a period.
- R7: Falling edges, a held high level and tick pulses between edges produce no strobe.
- R8: While `period_vld` is 1 and no strobe occurs, `period_ticks` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-clock pulse per 100 ns timebase tick |
| trk_a | input | 1 | Encoder track A, asynchronous |
| period_ticks | output | CNT_W | Last measured period in ticks, saturating; 0 when not valid |
| period_stb | output | 1 | One-clock pulse when `period_ticks` takes a new period |
| period_vld | output | 1 | A valid period is held on `period_ticks` |

## Verification
Some properties are checked every cycle by assertions. These are: the strobe lasts one clock and never appears without the valid flag, the period reads zero whenever it is not valid, a valid period only changes on a strobe, a detected edge lasts one cycle, and the running count is frozen in cycles without a tick. Other behaviour can only be shown by the bench's scenarios, which compare the complete sequence of reported periods and timeouts against a pin-level model. That covers the exact tick count per interval, the arm-only first edge, saturation, and the boundary between an interval of TIMEOUT_TICKS-1 ticks and a timeout. The stimulus mixes sparse and dense tick patterns with random pulse widths and long quiet gaps.

// File: rtl/pt_pkg.sv
package pt_pkg;
  // measurement state of the interval counter
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } arm_state_t;

  // one sampled pair of inputs travelling down the synchroniser
  typedef struct packed {
    logic a;
    logic tick;
  } line_t;
endpackage

// File: rtl/pt_align.sv
module pt_align
  import pt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trk_a,
  input  logic tick_en,
  output logic a_rise,
  output logic tick_d
);
  // track and tick share one pipeline so their alignment at the pins is kept
  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      line_t q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= '{a: trk_a, tick: tick_en};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= g_stage[g-1].q;
        end
      end
    end
  endgenerate

  line_t tail;
  logic  a_prev;
  assign tail = g_stage[STAGES-1].q;

  always_ff @(posedge clk) begin
    if (rst) a_prev <= 1'b0;
    else     a_prev <= tail.a;
  end

  assign a_rise = tail.a & ~a_prev;
  assign tick_d = tail.tick;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    a_rise |=> !a_rise); // R7
endmodule

// File: rtl/pt_interval.sv
module pt_interval
  import pt_pkg::*;
#(
  parameter int CNT_W         = 24,
  parameter int TIMEOUT_TICKS = 16_000_000,
  parameter int TO_W          = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_rise,
  input  logic             tick_d,
  output logic             evt_period,
  output logic [CNT_W-1:0] evt_value,
  output logic             evt_timeout
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [TO_W:0]    TO_LIM  = (TO_W+1)'(TIMEOUT_TICKS);

  arm_state_t       st;
  logic [CNT_W-1:0] cnt;    // saturating period count
  logic [TO_W-1:0]  tcnt;   // full-range count for the timeout
  logic [TO_W:0]    tnext;
  logic             expire;

  assign tnext  = {1'b0, tcnt} + 1'b1;
  assign expire = (st == ST_ARMED) && !a_rise && tick_d && (tnext >= TO_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      tcnt <= '0;
    end else if (a_rise) begin
      st   <= ST_ARMED;
      cnt  <= {{(CNT_W-1){1'b0}}, tick_d};
      tcnt <= {{(TO_W-1){1'b0}}, tick_d};
    end else if (expire) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      tcnt <= '0;
    end else if (st == ST_ARMED && tick_d) begin
      tcnt <= tnext[TO_W-1:0];
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  assign evt_period  = a_rise && (st == ST_ARMED);
  assign evt_value   = cnt;
  assign evt_timeout = expire;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARMED && !a_rise && !tick_d) |=> $stable(cnt)); // R2
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    evt_timeout |=> (st == ST_IDLE && cnt == '0)); // R6
endmodule

// File: rtl/pt_result.sv
module pt_result #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_period,
  input  logic [CNT_W-1:0] evt_value,
  input  logic             evt_timeout,
  output logic [CNT_W-1:0] period_ticks,
  output logic             period_stb,
  output logic             period_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      period_ticks <= '0;
      period_stb   <= 1'b0;
      period_vld   <= 1'b0;
    end else begin
      period_stb <= evt_period;
      if (evt_period) begin
        period_ticks <= evt_value;
        period_vld   <= 1'b1;
      end else if (evt_timeout) begin
        period_ticks <= '0;
        period_vld   <= 1'b0;
      end
    end
  end

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    period_stb |=> !period_stb); // R3
  AST_STB_VALID: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> period_vld); // R3
  AST_ZERO_WHEN_INVALID: assert property (@(posedge clk) disable iff (rst)
    !period_vld |-> (period_ticks == '0)); // R6
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst)
    (period_vld && !period_stb) |-> $stable(period_ticks)); // R8
endmodule

// File: rtl/edge_period_timer.sv
module edge_period_timer #(
  parameter int CNT_W         = 24,
  parameter int TIMEOUT_TICKS = 16_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             trk_a,
  output logic [CNT_W-1:0] period_ticks,
  output logic             period_stb,
  output logic             period_vld
);
  localparam int TO_W = $clog2(TIMEOUT_TICKS + 1);

  logic             a_rise;
  logic             tick_d;
  logic             evt_period;
  logic             evt_timeout;
  logic [CNT_W-1:0] evt_value;

  pt_align #(
    .STAGES(SYNC_STAGES)
  ) u_align (
    .clk    (clk),
    .rst    (rst),
    .trk_a  (trk_a),
    .tick_en(tick_en),
    .a_rise (a_rise),
    .tick_d (tick_d)
  );

  pt_interval #(
    .CNT_W        (CNT_W),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .TO_W         (TO_W)
  ) u_interval (
    .clk        (clk),
    .rst        (rst),
    .a_rise     (a_rise),
    .tick_d     (tick_d),
    .evt_period (evt_period),
    .evt_value  (evt_value),
    .evt_timeout(evt_timeout)
  );

  pt_result #(
    .CNT_W(CNT_W)
  ) u_result (
    .clk         (clk),
    .rst         (rst),
    .evt_period  (evt_period),
    .evt_value   (evt_value),
    .evt_timeout (evt_timeout),
    .period_ticks(period_ticks),
    .period_stb  (period_stb),
    .period_vld  (period_vld)
  );
endmodule

// File: tb/edge_period_timer_tb.sv
`timescale 1ns/1ps
module edge_period_timer_tb;
  localparam int CNT_W = 6;
  localparam int TO    = 100;
  localparam int SYNC  = 3;
  localparam int MAXV  = (1 << CNT_W) - 1;
  localparam int MAXN  = 60000;
  localparam int MAXE  = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0;
  logic trk_a = 1'b0;
  logic [CNT_W-1:0] period_ticks;
  logic period_stb, period_vld;

  always #2 clk = ~clk;

  edge_period_timer #(.CNT_W(CNT_W), .TIMEOUT_TICKS(TO), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .trk_a(trk_a),
    .period_ticks(period_ticks), .period_stb(period_stb), .period_vld(period_vld));

  int total = 0, bad = 0;
  bit done = 0;
  bit sa [MAXN];
  bit st [MAXN];
  int n = 0;
  int exp_ev [MAXE];
  int dut_ev [MAXE];
  int ne_exp = 0, ne_dut = 0;
  bit mon_on = 0;
  bit prev_vld = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // tick pattern: mode 0 every cycle, else roughly one in mode cycles
  function automatic bit tick_of(input int mode);
    if (mode == 0) return 1'b1;
    return ($urandom_range(mode - 1) == 0);
  endfunction

  task automatic add_seg(input int hi, input int lo, input int mode);
    for (int i = 0; i < hi && n < MAXN; i++) begin sa[n] = 1; st[n] = tick_of(mode); n++; end
    for (int i = 0; i < lo && n < MAXN; i++) begin sa[n] = 0; st[n] = tick_of(mode); n++; end
  endtask

  // pin-level reference: events are period values, or -1 for a timeout
  task automatic build_expect();
    bit prev = 0, armed = 0, vld = 0;
    int cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (sa[i] && !prev) begin
        if (armed) begin
          exp_ev[ne_exp++] = (cnt > MAXV) ? MAXV : cnt;   // R2, R5
          vld = 1;
        end
        armed = 1;                                        // R4
        cnt = st[i] ? 1 : 0;
      end else if (armed && st[i]) begin
        if (cnt + 1 >= TO) begin                          // R6
          armed = 0;
          cnt = 0;
          if (vld) exp_ev[ne_exp++] = -1;
          vld = 0;
        end else cnt++;
      end
      prev = sa[i];
    end
  endtask

  // monitor samples just after each rising edge
  always @(posedge clk) begin
    #1;
    if (mon_on && !done) begin
      if (period_stb) begin
        check(period_vld === 1'b1, "R3 valid with strobe", int'(period_vld), 1);
        if (ne_dut < MAXE) dut_ev[ne_dut++] = int'(period_ticks);
      end
      if (prev_vld && !period_vld) begin
        check(period_ticks == 0, "R6 zero after timeout", int'(period_ticks), 0);
        if (ne_dut < MAXE) dut_ev[ne_dut++] = -1;
      end
      prev_vld = period_vld;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // directed corner cases, tick every cycle so ticks equal cycles
    add_seg(0, 6, 0);
    for (int k = 0; k < 4; k++) add_seg(5, 5, 0);   // periods of 10
    add_seg(1, 61, 0);                              // 62
    add_seg(1, 62, 0);                              // 63 = max
    add_seg(1, 69, 0);                              // 70 saturates (R5)
    add_seg(1, TO - 2, 0);                          // TO-1 still reported (R6)
    add_seg(1, TO - 1, 0);                          // TO ticks: timeout
    add_seg(3, 17, 0);                              // arm only (R4)
    add_seg(3, 17, 0);                              // 20
    add_seg(40, 4, 0);                              // long high, no extra strobe (R7)
    add_seg(1, 160, 0);                             // timeout
    // random mix
    for (int k = 0; k < 320; k++) begin
      int mode = $urandom_range(3);
      int hi = $urandom_range(20, 1);
      int lo = ($urandom_range(15) == 0) ? $urandom_range(260, 100) : $urandom_range(60, 1);
      add_seg(hi, lo, mode);
    end
    add_seg(0, 12, 0);
    for (int i = n - 12; i < n; i++) st[i] = 0;
    build_expect();

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(period_ticks == 0, "R1 period in reset", int'(period_ticks), 0);
    check(period_stb == 0, "R1 strobe in reset", int'(period_stb), 0);
    check(period_vld == 0, "R1 valid in reset", int'(period_vld), 0);
    @(negedge clk);
    rst = 1'b0;
    mon_on = 1;
    @(posedge clk);
    #1;
    check(period_vld == 0 && period_stb == 0, "R1 after release", int'(period_vld), 0);

    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trk_a = sa[i];
      tick_en = st[i];
    end
    repeat (SYNC + 6) @(posedge clk);
    #2;
    done = 1;

    // R4, R7: no missing and no extra strobes or timeouts
    check(ne_dut == ne_exp, "R4 R7 event count", ne_dut, ne_exp);
    for (int k = 0; k < ne_exp && k < ne_dut; k++) begin
      if (exp_ev[k] < 0)         check(dut_ev[k] == exp_ev[k], "R6 timeout event", dut_ev[k], exp_ev[k]);
      else if (exp_ev[k] == MAXV) check(dut_ev[k] == exp_ev[k], "R5 saturated period", dut_ev[k], exp_ev[k]);
      else                        check(dut_ev[k] == exp_ev[k], "R2 period value", dut_ev[k], exp_ev[k]);
    end
    // R8: last value still held after the quiet tail
    if (ne_exp > 0 && exp_ev[ne_exp-1] >= 0)
      check(int'(period_ticks) == exp_ev[ne_exp-1], "R8 held value", int'(period_ticks), exp_ev[ne_exp-1]);
    else
      check(period_ticks == 0, "R8 held zero", int'(period_ticks), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule